// File: doc/BRIEF.md
# Three-Phase Inverter Output Sequencer

This block produces the six gate-level signals of a three-phase inverter bridge: the three phase outputs and their three complements. Software stages two 6-bit patterns in a pair of staging buffers through a small register port. A transfer trigger (normally the carrier timer event) moves both staged patterns into an internal sequencing stage. The first pattern is applied to all six outputs at once. The second pattern is then applied one phase at a time, each phase switching when its own one-shot pulse input falls. A read of either buffer address returns the pattern the outputs are applying at that moment.

Two safety and timing controls sit in a mode register. Software can write it only while an external write-protect release input is high. One bit arms an emergency cutoff. Once armed, a low level on the active-low NMI input latches all six outputs into high impedance, which is shown by a per-output enable that goes low. The other bit chooses which event strobes the carrier timer reload: every carrier underflow, or every odd-numbered timer-A output event.

Top module: `tri_phase_seq`

## Requirements
- R1: After reset, `phase_out` is all ones (every output inactive), `phase_oe` is all ones, `reload_pulse` is 0, and the mode register and both staging buffers read back as 0 through their own state.
- R2: A write with `wr_sel`=0 stores `wr_data[5:0]` into staging buffer 0, and a write with `wr_sel`=1 stores it into staging buffer 1. Bits 7:6 of the written data are dropped. Bit order in every pattern, from bit 0 upward: U, V, W, complement U, complement V, complement W.
- R3: With `rd_sel` equal to 0 or 1, `rd_data` is the pattern applied to the outputs, zero-extended. It is not the last value written. With `rd_sel`=2 it is the mode register, zero-extended. With `rd_sel`=3 it is 0.
- R4: When `xfer_trig` is high at a clock edge, `phase_out` equals staging buffer 0 from that edge on, and staging buffer 1 is captured for later use. A pattern bit of 0 drives the pin low (active level), and a bit of 1 drives it high (inactive level).
- R5: A falling edge on `pulse_in[p]` (high at one edge, low at the next) loads bits p and p+3 of `phase_out` from the captured buffer-1 pattern at that edge. All other bits keep their value.
- R6: If `xfer_trig` and a falling pulse edge occur at the same edge, buffer 0 is applied and the pulse edge has no effect.
- R7: Mode register field positions are: bit 0 selects the reload source, and bit 1 arms the cutoff. Its reset value is 0.
- R8: A write with `wr_sel`=2 updates the mode register only while `unlock` is high. With `unlock` low it leaves the register unchanged.
- R9: While the cutoff is armed, `nmi_n` sampled low drives all of `phase_oe` low from the next edge.
- R10: The cutoff stays latched until an edge where `nmi_n` is high and the arm bit is 0 at the same time. `nmi_n` low with the arm bit at 0 neither sets nor clears it.
- R11: With reload select 0, `reload_pulse` is high for one cycle, one edge after each cycle in which `tmr_under` is high.
- R12: With reload select 1, `reload_pulse` follows the 1st, 3rd, 5th and later odd-numbered `tmr_a_evt` events, counted from the edge the select became 1, and `tmr_under` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 buffer 0, 1 buffer 1, 2 mode, 3 none |
| wr_data | input | 8 | Write data |
| unlock | input | 1 | Write-protect release for the mode register |
| rd_sel | input | 2 | Read source select, same encoding as `wr_sel` |
| rd_data | output | 8 | Read data |
| xfer_trig | input | 1 | Transfer trigger |
| pulse_in | input | 3 | One-shot pulses for U, V, W |
| nmi_n | input | 1 | Active-low emergency input |
| tmr_under | input | 1 | Carrier timer underflow event |
| tmr_a_evt | input | 1 | Timer-A output event |
| phase_out | output | 6 | Pin levels, active low |
| phase_oe | output | 6 | Output enables, low during cutoff |
| reload_pulse | output | 1 | Carrier reload strobe |

## Verification
The bench builds the block with its defaults: three phases, 8-bit register data and the registered cutoff variant. This puts every field boundary in reach: the two dropped data bits, the complement offset of three, and a trigger colliding with a pulse edge. A behavioural model is compared on every cycle. Directed passages cover a protected write, cutoff held across an NMI release while still armed and across disarming while NMI is low, and odd-event counting after a reload-select change.

// File: rtl/tps_pkg.sv
package tps_pkg;
   typedef enum logic [1:0] {
      SEL_BUF0 = 2'd0,
      SEL_BUF1 = 2'd1,
      SEL_MODE = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int MODE_RELOAD_BIT = 0;
   localparam int MODE_CUT_BIT    = 1;
   localparam int MODE_W          = 2;
endpackage

// File: rtl/tps_regs.sv
module tps_regs
   import tps_pkg::*;
#(
   parameter int NPH = 3,
   parameter int DW  = 8,
   localparam int PW = 2 * NPH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          unlock,
   input  logic [1:0]    rd_sel,
   input  logic [PW-1:0] applied,
   output logic [PW-1:0] buf0_q,
   output logic [PW-1:0] buf1_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [DW-1:0] rd_data
);
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf0_q <= '0;
         buf1_q <= '0;
         mode_q <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_BUF0: buf0_q <= wr_data[PW-1:0];
            SEL_BUF1: buf1_q <= wr_data[PW-1:0];
            SEL_MODE: if (unlock) mode_q <= wr_data[MODE_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_sel_e'(rd_sel))
         SEL_BUF0, SEL_BUF1: rd_data[PW-1:0]     = applied;
         SEL_MODE:           rd_data[MODE_W-1:0] = mode_q;
         default:            rd_data             = '0;
      endcase
   end
endmodule

// File: rtl/tps_shift.sv
module tps_shift #(
   parameter int NPH = 3,
   localparam int PW = 2 * NPH
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig,
   input  logic [NPH-1:0] pulse_in,
   input  logic [PW-1:0]  buf0,
   input  logic [PW-1:0]  buf1,
   output logic [PW-1:0]  applied
);
   logic [NPH-1:0] pulse_d;
   logic [NPH-1:0] fall;
   logic [PW-1:0]  stage1_q;

   assign fall = pulse_d & ~pulse_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_d  <= '0;
         stage1_q <= '1;
      end else begin
         pulse_d <= pulse_in;
         if (trig) stage1_q <= buf1;
      end
   end

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      logic [1:0] pair_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            pair_q <= 2'b11;
         else if (trig)
            pair_q <= {buf0[p+NPH], buf0[p]};
         else if (fall[p])
            pair_q <= {stage1_q[p+NPH], stage1_q[p]};
      end
      assign applied[p]     = pair_q[0];
      assign applied[p+NPH] = pair_q[1];
   end
endmodule

// File: rtl/tps_guard.sv
module tps_guard #(
   parameter int NPH         = 3,
   parameter bit FAST_CUTOFF = 1'b0,
   localparam int PW = 2 * NPH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cut_en,
   input  logic          rel_sel,
   input  logic          nmi_n,
   input  logic          tmr_under,
   input  logic          tmr_a_evt,
   output logic [PW-1:0] phase_oe,
   output logic          cut_q,
   output logic          reload_pulse
);
   logic odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cut_q        <= 1'b0;
         odd_q        <= 1'b0;
         reload_pulse <= 1'b0;
      end else begin
         if (cut_en && !nmi_n)
            cut_q <= 1'b1;
         else if (nmi_n && !cut_en)
            cut_q <= 1'b0;
         reload_pulse <= rel_sel ? (tmr_a_evt && !odd_q) : tmr_under;
         if (!rel_sel)
            odd_q <= 1'b0;
         else if (tmr_a_evt)
            odd_q <= ~odd_q;
      end
   end

   if (FAST_CUTOFF) begin : g_fast
      assign phase_oe = {PW{~(cut_q | (cut_en & ~nmi_n))}};
   end else begin : g_reg
      assign phase_oe = {PW{~cut_q}};
   end
endmodule

// File: rtl/tri_phase_seq.sv
module tri_phase_seq
   import tps_pkg::*;
#(
   parameter int NUM_PHASES  = 3,
   parameter int DATA_W      = 8,
   parameter bit FAST_CUTOFF = 1'b0,
   localparam int PW = 2 * NUM_PHASES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  unlock,
   input  logic [1:0]            rd_sel,
   output logic [DATA_W-1:0]     rd_data,
   input  logic                  xfer_trig,
   input  logic [NUM_PHASES-1:0] pulse_in,
   input  logic                  nmi_n,
   input  logic                  tmr_under,
   input  logic                  tmr_a_evt,
   output logic [PW-1:0]         phase_out,
   output logic [PW-1:0]         phase_oe,
   output logic                  reload_pulse
);
   if (NUM_PHASES < 1) begin : g_bad_phases
      $error("tri_phase_seq: NUM_PHASES must be at least 1");
   end
   if (DATA_W < PW || DATA_W < MODE_W) begin : g_bad_width
      $error("tri_phase_seq: DATA_W too narrow for pattern or mode");
   end

   logic [PW-1:0]     buf0_q;
   logic [PW-1:0]     buf1_q;
   logic [MODE_W-1:0] mode_q;
   logic              cut_q;

   tps_regs #(.NPH(NUM_PHASES), .DW(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .unlock  (unlock),
      .rd_sel  (rd_sel),
      .applied (phase_out),
      .buf0_q  (buf0_q),
      .buf1_q  (buf1_q),
      .mode_q  (mode_q),
      .rd_data (rd_data)
   );

   tps_shift #(.NPH(NUM_PHASES)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (xfer_trig),
      .pulse_in (pulse_in),
      .buf0     (buf0_q),
      .buf1     (buf1_q),
      .applied  (phase_out)
   );

   tps_guard #(.NPH(NUM_PHASES), .FAST_CUTOFF(FAST_CUTOFF)) u_guard (
      .clk          (clk),
      .rst_n        (rst_n),
      .cut_en       (mode_q[MODE_CUT_BIT]),
      .rel_sel      (mode_q[MODE_RELOAD_BIT]),
      .nmi_n        (nmi_n),
      .tmr_under    (tmr_under),
      .tmr_a_evt    (tmr_a_evt),
      .phase_oe     (phase_oe),
      .cut_q        (cut_q),
      .reload_pulse (reload_pulse)
   );
endmodule

// File: rtl/tps_chk.sv
module tps_chk #(
   parameter int NPH = 3,
   localparam int PW = 2 * NPH
) (
   input logic          clk,
   input logic          rst_n,
   input logic          xfer_trig,
   input logic          nmi_n,
   input logic          tmr_under,
   input logic          wr_en,
   input logic [1:0]    wr_sel,
   input logic          unlock,
   input logic [PW-1:0] phase_out,
   input logic [PW-1:0] phase_oe,
   input logic          reload_pulse,
   input logic [PW-1:0] buf0_q,
   input logic [1:0]    mode_q
);
   // R4
   trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_trig |=> phase_out == $past(buf0_q));

   // R9
   cutoff_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && !nmi_n) |=> phase_oe == '0);

   // R10
   cutoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_oe == '0 && !(nmi_n && !mode_q[1])) |=> phase_oe == '0);

   // R8
   mode_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !unlock) |=> $stable(mode_q));

   // R11
   reload_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[0] |=> reload_pulse == $past(tmr_under));
endmodule

bind tri_phase_seq tps_chk #(.NPH(NUM_PHASES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xfer_trig    (xfer_trig),
   .nmi_n        (nmi_n),
   .tmr_under    (tmr_under),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .unlock       (unlock),
   .phase_out    (phase_out),
   .phase_oe     (phase_oe),
   .reload_pulse (reload_pulse),
   .buf0_q       (buf0_q),
   .mode_q       (mode_q)
);

// File: tb/sim_tri_phase_seq.sv
module sim_tri_phase_seq;
   localparam int NPH = 3;
   localparam int W   = 6;
   localparam int DW  = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd3;
   logic [DW-1:0] wr_data = '0;
   logic          unlock = 1'b0;
   logic [1:0]    rd_sel = 2'd0;
   logic [DW-1:0] rd_data;
   logic          xfer_trig = 1'b0;
   logic [NPH-1:0] pulse_in = '0;
   logic          nmi_n = 1'b1;
   logic          tmr_under = 1'b0;
   logic          tmr_a_evt = 1'b0;
   logic [W-1:0]  phase_out;
   logic [W-1:0]  phase_oe;
   logic          reload_pulse;

   tri_phase_seq u0 (.*);

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   logic [W-1:0] m_b0, m_b1, m_st1, m_app;
   logic [1:0]   m_mode;
   logic [NPH-1:0] m_prev;
   logic m_cut, m_odd, m_rel;

   always @(posedge clk) begin
      logic [W-1:0] b0o, b1o;
      logic [1:0] mo;
      if (!rst_n) begin
         m_b0 = '0; m_b1 = '0; m_st1 = '1; m_app = '1;
         m_mode = '0; m_prev = '0; m_cut = 0; m_odd = 0; m_rel = 0;
      end else begin
         b0o = m_b0; b1o = m_b1; mo = m_mode;
         if (xfer_trig) begin
            m_app = b0o;
            m_st1 = b1o;
         end else begin
            for (int p = 0; p < NPH; p++)
               if (m_prev[p] && !pulse_in[p]) begin
                  m_app[p]     = m_st1[p];
                  m_app[p+NPH] = m_st1[p+NPH];
               end
         end
         m_prev = pulse_in;
         if (wr_en) begin
            if (wr_sel == 2'd0) m_b0 = wr_data[W-1:0];
            if (wr_sel == 2'd1) m_b1 = wr_data[W-1:0];
            if (wr_sel == 2'd2 && unlock) m_mode = wr_data[1:0];
         end
         if (mo[1] && !nmi_n) m_cut = 1;
         else if (nmi_n && !mo[1]) m_cut = 0;
         m_rel = mo[0] ? (tmr_a_evt && !m_odd) : tmr_under;
         if (!mo[0]) m_odd = 0;
         else if (tmr_a_evt) m_odd = !m_odd;
      end
   end

   function automatic logic [DW-1:0] model_rd(input logic [1:0] s);
      case (s)
         2'd0, 2'd1: return {2'b00, m_app};
         2'd2:       return {6'b0, m_mode};
         default:    return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 R5 R6 model phase_out", phase_out, m_app);
         chk("R9 R10 model phase_oe", phase_oe, {W{~m_cut}});
         chk("R11 R12 model reload_pulse", reload_pulse, m_rel);
         chk("R3 R7 model rd_data", rd_data, model_rd(rd_sel));
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d, input logic u);
      wr_en = 1; wr_sel = s; wr_data = d; unlock = u;
      tick();
      wr_en = 0; wr_sel = 2'd3; unlock = 0;
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 phase_out", phase_out, 6'h3F);
      chk("R1 phase_oe", phase_oe, 6'h3F);
      chk("R1 reload_pulse", reload_pulse, 0);
      rd_sel = 2'd2; #1;
      chk("R1 R7 mode reads 0", rd_data, 8'h00);

      // R2 buffer writes, upper bits dropped; R3 read shows applied, not written
      wr(2'd0, 8'hEA, 0);
      wr(2'd1, 8'h15, 0);
      rd_sel = 2'd0; #1;
      chk("R3 read buf0 returns applied", rd_data, 8'h3F);
      // R4 trigger applies buffer 0
      xfer_trig = 1; tick(); xfer_trig = 0;
      chk("R4 R2 trigger applies buf0", phase_out, 6'h2A);
      rd_sel = 2'd1; #1;
      chk("R3 read buf1 returns applied", rd_data, 8'h2A);

      // R5 U falling edge then V falling edge
      pulse_in = 3'b001; tick();
      chk("R5 rising edge no change", phase_out, 6'h2A);
      pulse_in = 3'b000; tick();
      chk("R5 U pair from buf1", phase_out, 6'h23);
      pulse_in = 3'b010; tick();
      pulse_in = 3'b000; tick();
      chk("R5 V pair from buf1", phase_out, 6'h31);

      // R6 trigger beats simultaneous W falling edge
      wr(2'd0, 8'h00, 0);
      pulse_in = 3'b100; tick();
      pulse_in = 3'b000; xfer_trig = 1; tick(); xfer_trig = 0;
      chk("R6 trigger wins over pulse", phase_out, 6'h00);

      // R8 protected mode write
      rd_sel = 2'd2;
      wr(2'd2, 8'h03, 0);
      chk("R8 locked write ignored", rd_data, 8'h00);
      wr(2'd2, 8'h01, 1);
      chk("R8 R7 unlocked write", rd_data, 8'h01);

      // R12 odd timer-A events, underflow ignored
      tmr_under = 1; tick(); tmr_under = 0;
      chk("R12 underflow ignored", reload_pulse, 0);
      tmr_a_evt = 1; tick();
      chk("R12 1st event", reload_pulse, 1);
      tick();
      chk("R12 2nd event", reload_pulse, 0);
      tick();
      chk("R12 3rd event", reload_pulse, 1);
      tmr_a_evt = 0; tick();
      chk("R12 idle", reload_pulse, 0);

      // R11 underflow source
      wr(2'd2, 8'h00, 1);
      tmr_under = 1; tick(); tmr_under = 0;
      chk("R11 underflow strobe", reload_pulse, 1);
      tick();
      chk("R11 one cycle", reload_pulse, 0);

      // R10 NMI without arm has no effect
      nmi_n = 0; tick(); tick();
      chk("R10 unarmed nmi ignored", phase_oe, 6'h3F);
      nmi_n = 1;
      // R9 armed cutoff
      wr(2'd2, 8'h02, 1);
      nmi_n = 0; tick();
      chk("R9 cutoff asserted", phase_oe, 6'h00);
      nmi_n = 1; tick(); tick();
      chk("R10 held while armed", phase_oe, 6'h00);
      nmi_n = 0;
      wr(2'd2, 8'h00, 1);
      tick();
      chk("R10 held while nmi low", phase_oe, 6'h00);
      nmi_n = 1; tick();
      chk("R10 released", phase_oe, 6'h3F);

      repeat (4) tick();
      done = 1;
      summary();
      $finish;
   end
endmodule